// File: doc/BRIEF.md
# Word-to-Byte Data Port Bridge

This block connects the 32-bit data registers of a serial peripheral controller to its byte-wide transmit and receive queues. A write to one of the transmit data addresses cuts the written word into bytes and hands them to the transmit queue one per clock. A read of the receive data address takes bytes from the receive queue one per clock and packs them into a word. An endian bit in the controller's configuration word selects the byte order. The order is either least significant byte first, or bits 31:24 first moving downward.

The number of bytes moved depends on the address. The main transmit and receive data addresses move a default count, set by a parameter from 1 to 4. Three transmit alias addresses move exactly one, two or three bytes. A transfer ends early, and silently, when the transmit queue fills or the receive queue empties. While a transfer is in progress the block raises `busy`, and the register bus must hold off. Completion is marked by a one-cycle `done`, with the assembled word on `rdata` for reads.

Top module: `pk_word_byte_bridge`

## Requirements
- R1: After reset `busy`, `done` and `rdata` are 0, and neither `tx_push` nor `rx_pop` is asserted.
- R2: A write accepted at the main transmit address (default 0x1C) pushes DEF_BYTES bytes into the transmit queue when it has room.
- R3: Writes to the alias addresses 0x80, 0x84 and 0x88 push exactly 1, 2 and 3 bytes, whatever DEF_BYTES is.
- R4: With bit 26 of `cfg_word` clear, the k-th pushed byte (k from 0) is `wdata[8k+7:8k]`.
- R5: With bit 26 of `cfg_word` set, the k-th pushed byte is `wdata[31-8k:24-8k]`, so the first byte is bits 31:24.
- R6: If `tx_full` is seen before the count is reached, pushing stops, the remaining bytes are dropped, and the transfer completes with no error.
- R7: A read accepted at the receive address (default 0x20) pops min(DEF_BYTES, queue level) bytes. `rdata` starts from zero, so lanes that are not filled read 0, and the bytes that are not popped stay queued.
- R8: With bit 26 clear, the k-th popped byte lands in `rdata[8k+7:8k]`. With it set, it lands in `rdata[31-8k:24-8k]`.
- R9: A request is taken when `req_valid` is high and `busy` is low. One byte moves per clock from the cycle after acceptance. `busy` is high until completion, and `done` is raised in the cycle after the last push or pop, or after the cycle in which the queue was found full or empty. For a full transfer of n bytes, `done` is seen n+1 cycles after acceptance. A request made while `busy` is high is not taken.
- R10: An access that matches no data address, or has the wrong direction for it, moves no byte, never raises `busy`, and returns `done` with `rdata` 0 one cycle after acceptance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Register access request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Register byte offset |
| req_wdata | input | DATA_W | Write data word |
| cfg_word | input | 32 | Controller configuration word; bit ENDIAN_BIT selects byte order |
| busy | output | 1 | Transfer in progress; bus must stall |
| done | output | 1 | One-cycle completion strobe |
| rdata | output | DATA_W | Assembled read word, valid with done |
| tx_push | output | 1 | Push strobe to transmit queue |
| tx_byte | output | 8 | Byte for transmit queue |
| tx_full | input | 1 | Transmit queue full |
| rx_pop | output | 1 | Pop strobe to receive queue |
| rx_byte | input | 8 | Head byte of receive queue |
| rx_empty | input | 1 | Receive queue empty |

## Verification
The hardest situation to reach is a queue boundary in the middle of a word. The transmit queue must fill after one or two bytes of a multi-byte write, or the receive queue must run dry partway through a read. Only then do the early stop, the dropped tail and the zero upper lanes show up. The bench's queue models can be preset to any level before each access, and the random mix favours transmit levels of 29 to 32 and receive levels of 0 to 5. Directed cases add a request held up during `busy` and accesses with the wrong direction.

// File: rtl/pk_bridge_pkg.sv
package pk_bridge_pkg;

  typedef enum logic [1:0] {
    OP_NONE = 2'd0,
    OP_TX   = 2'd1,
    OP_RX   = 2'd2
  } op_kind_e;

  // Byte lane visited at step idx of a transfer across lanes byte lanes.
  function automatic int unsigned lane_of(input int unsigned idx,
                                          input int unsigned lanes,
                                          input logic msb_first);
    return msb_first ? (lanes - 1 - idx) : idx;
  endfunction

  // Bytes actually moved given the request count and room in the queue.
  function automatic int unsigned moved_bytes(input int unsigned want,
                                              input int unsigned room);
    return (want < room) ? want : room;
  endfunction

endpackage

// File: rtl/pk_addr_decode.sv
module pk_addr_decode
  import pk_bridge_pkg::*;
#(
  parameter int ADDR_W     = 8,
  parameter int LANES      = 4,
  parameter int CNT_W      = 3,
  parameter int DEF_BYTES  = 1,
  parameter int TX_OFS     = 'h1C,
  parameter int RX_OFS     = 'h20,
  parameter int ALIAS_BASE = 'h80
) (
  input  logic              write_i,
  input  logic [ADDR_W-1:0] addr_i,
  output op_kind_e          kind_o,
  output logic [CNT_W-1:0]  count_o
);

  localparam int NUM_ALIAS = LANES - 1;

  logic [NUM_ALIAS-1:0] alias_hit;
  logic                 main_tx_hit;
  logic                 rx_hit;

  assign main_tx_hit = write_i && (addr_i == ADDR_W'(TX_OFS));
  assign rx_hit      = !write_i && (addr_i == ADDR_W'(RX_OFS));

  // Alias k moves exactly k+1 bytes.
  for (genvar k = 0; k < NUM_ALIAS; k++) begin : g_alias
    assign alias_hit[k] = write_i && (addr_i == ADDR_W'(ALIAS_BASE + 4 * k));
  end

  always_comb begin
    kind_o  = OP_NONE;
    count_o = '0;
    if (main_tx_hit) begin
      kind_o  = OP_TX;
      count_o = CNT_W'(DEF_BYTES);
    end else if (rx_hit) begin
      kind_o  = OP_RX;
      count_o = CNT_W'(DEF_BYTES);
    end else begin
      for (int k = 0; k < NUM_ALIAS; k++) begin
        if (alias_hit[k]) begin
          kind_o  = OP_TX;
          count_o = CNT_W'(k + 1);
        end
      end
    end
  end

endmodule

// File: rtl/pk_tx_slicer.sv
module pk_tx_slicer
  import pk_bridge_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int CNT_W  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [CNT_W-1:0]  count_i,
  input  logic [DATA_W-1:0] word_i,
  input  logic              msb_i,
  input  logic              tx_full_i,
  output logic              busy_o,
  output logic              finish_o,
  output logic              tx_push_o,
  output logic [7:0]        tx_byte_o
);

  localparam int LANES = DATA_W / 8;
  localparam int IDX_W = (LANES > 1) ? $clog2(LANES) : 1;

  logic              active_q;
  logic [DATA_W-1:0] word_q;
  logic              msb_q;
  logic [CNT_W-1:0]  left_q;
  logic [IDX_W-1:0]  idx_q;
  logic [IDX_W-1:0]  lane;
  logic [7:0]        lane_bytes [LANES];
  logic              last_step;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign lane_bytes[g] = word_q[8*g +: 8];
  end

  assign lane      = IDX_W'(lane_of(int'(idx_q), LANES, msb_q));
  assign tx_byte_o = lane_bytes[lane];
  assign tx_push_o = active_q && !tx_full_i;
  assign last_step = (left_q == CNT_W'(1));
  assign finish_o  = active_q && (tx_full_i || last_step);
  assign busy_o    = active_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      word_q   <= '0;
      msb_q    <= 1'b0;
      left_q   <= '0;
      idx_q    <= '0;
    end else if (start_i) begin
      active_q <= (count_i != '0);
      word_q   <= word_i;
      msb_q    <= msb_i;
      left_q   <= count_i;
      idx_q    <= '0;
    end else if (active_q) begin
      if (finish_o) begin
        active_q <= 1'b0;
      end else if (tx_push_o) begin
        left_q <= left_q - CNT_W'(1);
        idx_q  <= idx_q + IDX_W'(1);
      end
    end
  end

  // R6
  full_ends_tx_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(active_q) && $past(tx_full_i) |-> !active_q);

  // R9
  word_held_tx_chk: assert property (@(posedge clk) disable iff (!rst_n)
    active_q && !start_i |=> $stable(word_q));

endmodule

// File: rtl/pk_rx_gather.sv
module pk_rx_gather
  import pk_bridge_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int CNT_W  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr_i,
  input  logic              start_i,
  input  logic [CNT_W-1:0]  count_i,
  input  logic              msb_i,
  input  logic              rx_empty_i,
  input  logic [7:0]        rx_byte_i,
  output logic              busy_o,
  output logic              finish_o,
  output logic              rx_pop_o,
  output logic [DATA_W-1:0] word_o
);

  localparam int LANES = DATA_W / 8;
  localparam int IDX_W = (LANES > 1) ? $clog2(LANES) : 1;

  logic              active_q;
  logic              msb_q;
  logic [CNT_W-1:0]  left_q;
  logic [IDX_W-1:0]  idx_q;
  logic [IDX_W-1:0]  lane;
  logic [DATA_W-1:0] word_q;

  assign lane     = IDX_W'(lane_of(int'(idx_q), LANES, msb_q));
  assign rx_pop_o = active_q && !rx_empty_i;
  assign finish_o = active_q && (rx_empty_i || (left_q == CNT_W'(1)));
  assign busy_o   = active_q;
  assign word_o   = word_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      msb_q    <= 1'b0;
      left_q   <= '0;
      idx_q    <= '0;
    end else if (start_i) begin
      active_q <= (count_i != '0);
      msb_q    <= msb_i;
      left_q   <= count_i;
      idx_q    <= '0;
    end else if (active_q) begin
      if (finish_o) begin
        active_q <= 1'b0;
      end else if (rx_pop_o) begin
        left_q <= left_q - CNT_W'(1);
        idx_q  <= idx_q + IDX_W'(1);
      end
    end
  end

  // Each lane of the result is its own register slice.
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        word_q[8*g +: 8] <= '0;
      end else if (clr_i) begin
        word_q[8*g +: 8] <= '0;
      end else if (rx_pop_o && (lane == IDX_W'(g))) begin
        word_q[8*g +: 8] <= rx_byte_i;
      end
    end
  end

  // R7
  rx_clear_on_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> (word_q == '0));

  // R7
  empty_ends_rx_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(active_q) && $past(rx_empty_i) |-> !active_q);

  // R9
  rx_word_still_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !active_q && !clr_i |=> $stable(word_q));

endmodule

// File: rtl/pk_word_byte_bridge.sv
module pk_word_byte_bridge
  import pk_bridge_pkg::*;
#(
  parameter int DATA_W     = 32,
  parameter int ADDR_W     = 8,
  parameter int DEF_BYTES  = 1,
  parameter int ENDIAN_BIT = 26,
  parameter int TX_OFS     = 'h1C,
  parameter int RX_OFS     = 'h20,
  parameter int ALIAS_BASE = 'h80
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [31:0]       cfg_word,
  output logic              busy,
  output logic              done,
  output logic [DATA_W-1:0] rdata,
  output logic              tx_push,
  output logic [7:0]        tx_byte,
  input  logic              tx_full,
  output logic              rx_pop,
  input  logic [7:0]        rx_byte,
  input  logic              rx_empty
);

  localparam int LANES = DATA_W / 8;
  localparam int CNT_W = $clog2(LANES + 1);

  op_kind_e          kind;
  logic [CNT_W-1:0]  count;
  logic              accept;
  logic              tx_start;
  logic              rx_start;
  logic              null_start;
  logic              tx_busy;
  logic              rx_busy;
  logic              tx_finish;
  logic              rx_finish;
  logic              msb_first;
  logic              done_q;
  logic [31:0]       unused_cfg;

  assign unused_cfg = cfg_word;
  assign msb_first  = cfg_word[ENDIAN_BIT];

  pk_addr_decode #(
    .ADDR_W(ADDR_W), .LANES(LANES), .CNT_W(CNT_W), .DEF_BYTES(DEF_BYTES),
    .TX_OFS(TX_OFS), .RX_OFS(RX_OFS), .ALIAS_BASE(ALIAS_BASE)
  ) u_decode (
    .write_i (req_write),
    .addr_i  (req_addr),
    .kind_o  (kind),
    .count_o (count)
  );

  assign busy       = tx_busy || rx_busy;
  assign accept     = req_valid && !busy;
  assign tx_start   = accept && (kind == OP_TX);
  assign rx_start   = accept && (kind == OP_RX);
  assign null_start = accept && (kind == OP_NONE);

  pk_tx_slicer #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_tx (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_i   (tx_start),
    .count_i   (count),
    .word_i    (req_wdata),
    .msb_i     (msb_first),
    .tx_full_i (tx_full),
    .busy_o    (tx_busy),
    .finish_o  (tx_finish),
    .tx_push_o (tx_push),
    .tx_byte_o (tx_byte)
  );

  pk_rx_gather #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_rx (
    .clk        (clk),
    .rst_n      (rst_n),
    .clr_i      (accept),
    .start_i    (rx_start),
    .count_i    (count),
    .msb_i      (msb_first),
    .rx_empty_i (rx_empty),
    .rx_byte_i  (rx_byte),
    .busy_o     (rx_busy),
    .finish_o   (rx_finish),
    .rx_pop_o   (rx_pop),
    .word_o     (rdata)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_q <= 1'b0;
    end else begin
      done_q <= null_start || tx_finish || rx_finish;
    end
  end

  assign done = done_q;

  // R9
  busy_after_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept && (kind != OP_NONE) |=> busy);

  // R9
  busy_drop_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);

  // R9
  done_not_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  // R10
  null_access_chk: assert property (@(posedge clk) disable iff (!rst_n)
    null_start |=> done && !busy && (rdata == '0));

  // R9
  single_engine_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(tx_push && rx_pop));

endmodule

// File: tb/test_pk_word_byte_bridge.sv
module test_pk_word_byte_bridge;

  localparam int TB_DEF = 3;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid;
  logic        req_write;
  logic [7:0]  req_addr;
  logic [31:0] req_wdata;
  logic [31:0] cfg_word;
  logic        busy;
  logic        done;
  logic [31:0] rdata;
  logic        tx_push;
  logic [7:0]  tx_byte;
  logic        tx_full;
  logic        rx_pop;
  logic [7:0]  rx_byte;
  logic        rx_empty;

  always #5 clk = ~clk;

  pk_word_byte_bridge #(.DEF_BYTES(TB_DEF)) i_pk_word_byte_bridge (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .cfg_word(cfg_word),
    .busy(busy), .done(done), .rdata(rdata), .tx_push(tx_push),
    .tx_byte(tx_byte), .tx_full(tx_full), .rx_pop(rx_pop),
    .rx_byte(rx_byte), .rx_empty(rx_empty)
  );

  // Queue models, 32 deep, updated in one process.
  logic [7:0] rxq [32];
  logic [7:0] txlog [8];
  int rx_head = 0, rx_cnt = 0, tx_cnt = 0, tx_logn = 0;
  logic cmd_clr = 0, cmd_load = 0, cmd_lvl = 0;
  logic [7:0] cmd_byte = 0;
  int cmd_level = 0;

  assign tx_full  = (tx_cnt >= 32);
  assign rx_empty = (rx_cnt == 0);
  assign rx_byte  = rxq[rx_head];

  always @(posedge clk) begin
    if (cmd_clr) begin
      rx_head <= 0; rx_cnt <= 0; tx_cnt <= 0; tx_logn <= 0;
    end else if (cmd_load) begin
      rxq[(rx_head + rx_cnt) % 32] <= cmd_byte;
      rx_cnt <= rx_cnt + 1;
    end else if (cmd_lvl) begin
      tx_cnt <= cmd_level; tx_logn <= 0;
    end else begin
      if (tx_push) begin
        txlog[tx_logn % 8] <= tx_byte;
        tx_logn <= tx_logn + 1;
        tx_cnt <= tx_cnt + 1;
      end
      if (rx_pop) begin
        rx_head <= (rx_head + 1) % 32;
        rx_cnt <= rx_cnt - 1;
      end
    end
  end

  int checks = 0, failures = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] tb_slice(input logic [31:0] w, input int k, input bit msb);
    return msb ? w[24 - 8*k +: 8] : w[8*k +: 8];
  endfunction

  // kind: 0 none, 1 tx, 2 rx
  function automatic int tb_kind(input bit wr, input logic [7:0] a);
    if (wr && (a == 8'h1C || a == 8'h80 || a == 8'h84 || a == 8'h88)) return 1;
    if (!wr && a == 8'h20) return 2;
    return 0;
  endfunction

  function automatic int tb_count(input bit wr, input logic [7:0] a);
    if (wr && a == 8'h80) return 1;
    if (wr && a == 8'h84) return 2;
    if (wr && a == 8'h88) return 3;
    return TB_DEF;
  endfunction

  task automatic run_op(input bit wr, input logic [7:0] addr, input logic [31:0] data,
                        input bit msb, input int tx_level, input int rx_avail,
                        input bit poke, input string tag);
    logic [7:0] rb [4];
    logic [31:0] cfgv, exp_word, act_pack, exp_pack;
    int kind, n, m, lat, exp_lat;
    @(negedge clk); cmd_clr = 1;
    @(negedge clk); cmd_clr = 0; cmd_lvl = 1; cmd_level = tx_level;
    @(negedge clk); cmd_lvl = 0;
    for (int i = 0; i < rx_avail; i++) begin
      cmd_byte = 8'($urandom);
      if (i < 4) rb[i] = cmd_byte;
      cmd_load = 1;
      @(negedge clk);
    end
    cmd_load = 0;
    cfgv = $urandom; cfgv[26] = msb;
    req_valid = 1; req_write = wr; req_addr = addr; req_wdata = data; cfg_word = cfgv;
    @(negedge clk);
    req_valid = 0;
    lat = 1;
    if (poke && !done) begin
      req_valid = 1; req_write = 0; req_addr = 8'h20;
    end
    while (!done && lat < 60) begin
      @(negedge clk);
      req_valid = 0;
      lat++;
    end
    kind = tb_kind(wr, addr);
    n = tb_count(wr, addr);
    if (kind == 1) m = (n < 32 - tx_level) ? n : 32 - tx_level;
    else if (kind == 2) m = (n < rx_avail) ? n : rx_avail;
    else m = 0;
    exp_lat = (kind == 0) ? 1 : ((m == n) ? n + 1 : m + 2);
    chk(lat == exp_lat, "R9", {tag, " latency"}, lat, exp_lat);
    if (kind == 1) begin
      chk(tx_logn == m, (m < n) ? "R6" : tag, {tag, " pushed count"}, tx_logn, m);
      act_pack = 0; exp_pack = 0;
      for (int k = 0; k < m && k < 4; k++) begin
        act_pack = {act_pack[23:0], txlog[k]};
        exp_pack = {exp_pack[23:0], tb_slice(data, k, msb)};
      end
      chk(act_pack == exp_pack, msb ? "R5" : "R4", {tag, " byte order"}, act_pack, exp_pack);
      if (poke) chk(rx_cnt == rx_avail, "R9", "request during busy taken", rx_cnt, rx_avail);
    end else if (kind == 2) begin
      exp_word = 0;
      for (int k = 0; k < m; k++)
        exp_word = exp_word | (32'(rb[k]) << (msb ? 24 - 8*k : 8*k));
      chk(rdata == exp_word, msb ? "R8" : "R7", {tag, " read word"}, rdata, exp_word);
      chk(rx_cnt == rx_avail - m, "R7", {tag, " bytes left"}, rx_cnt, rx_avail - m);
    end else begin
      chk(tx_logn == 0, "R10", {tag, " no push"}, tx_logn, 0);
      chk(rx_cnt == rx_avail, "R10", {tag, " no pop"}, rx_cnt, rx_avail);
      chk(rdata == 0, "R10", {tag, " zero rdata"}, rdata, 0);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; failures++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [7:0] bad_addr [4];
    void'($urandom(32'h5EED));
    bad_addr[0] = 8'h00; bad_addr[1] = 8'h8C; bad_addr[2] = 8'h20; bad_addr[3] = 8'h1C;
    rst_n = 0; req_valid = 0; req_write = 0; req_addr = 0; req_wdata = 0; cfg_word = 0;
    repeat (3) @(negedge clk);
    // R1
    chk(busy == 0 && done == 0, "R1", "busy/done in reset", {busy, done}, 0);
    chk(rdata == 0, "R1", "rdata in reset", rdata, 0);
    chk(tx_push == 0 && rx_pop == 0, "R1", "strobes in reset", {tx_push, rx_pop}, 0);
    rst_n = 1;
    @(negedge clk);
    chk(busy == 0 && done == 0 && rdata == 0, "R1", "after reset", {busy, done}, 0);

    // Directed cases
    run_op(1, 8'h1C, 32'hA1B2C3D4, 0, 0, 0, 0, "R2");
    run_op(1, 8'h1C, 32'hA1B2C3D4, 1, 5, 0, 0, "R2");
    run_op(1, 8'h80, 32'h11223344, 0, 0, 0, 0, "R3");
    run_op(1, 8'h84, 32'h11223344, 1, 0, 0, 0, "R3");
    run_op(1, 8'h88, 32'h55667788, 0, 0, 0, 0, "R3");
    run_op(1, 8'h88, 32'h55667788, 1, 0, 0, 0, "R3");
    run_op(1, 8'h88, 32'hCAFEF00D, 0, 31, 0, 0, "R6");
    run_op(1, 8'h1C, 32'hCAFEF00D, 1, 32, 0, 0, "R6");
    run_op(1, 8'h84, 32'hCAFEF00D, 1, 30, 0, 0, "R6");
    run_op(0, 8'h20, 32'h0, 0, 0, 5, 0, "R7");
    run_op(0, 8'h20, 32'h0, 1, 0, 5, 0, "R8");
    run_op(0, 8'h20, 32'h0, 0, 0, 1, 0, "R7");
    run_op(0, 8'h20, 32'h0, 1, 0, 2, 0, "R8");
    run_op(0, 8'h20, 32'h0, 0, 0, 0, 0, "R7");
    run_op(1, 8'h1C, 32'h0BADBEEF, 0, 0, 3, 1, "R9");
    run_op(1, 8'h20, 32'h12345678, 0, 0, 3, 0, "R10");
    run_op(0, 8'h1C, 32'h0, 0, 0, 3, 0, "R10");
    run_op(1, 8'h8C, 32'h12345678, 1, 0, 2, 0, "R10");

    // Constrained random mix
    for (int t = 0; t < 200; t++) begin
      int sel, lvl, av;
      logic [31:0] w;
      sel = $urandom % 6;
      lvl = ($urandom % 3 == 0) ? 29 + ($urandom % 4) : $urandom % 20;
      av  = $urandom % 6;
      w   = $urandom;
      case (sel)
        0: run_op(1, 8'h1C, w, 1'($urandom), lvl, av, 0, "R2");
        1: run_op(1, 8'h80, w, 1'($urandom), lvl, av, 0, "R3");
        2: run_op(1, 8'h84, w, 1'($urandom), lvl, av, 0, "R3");
        3: run_op(1, 8'h88, w, 1'($urandom), lvl, av, 0, "R3");
        4: run_op(0, 8'h20, w, 1'($urandom), lvl, av, 0, "R7");
        default: begin
          int b;
          b = $urandom % 4;
          run_op((b == 2) ? 1'b1 : (b == 3) ? 1'b0 : 1'($urandom),
                 bad_addr[b], w, 1'($urandom), lvl, av, 0, "R10");
        end
      endcase
    end

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule